// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the general-purpose registers of a 32-bit processor that runs in seven operating modes. A register number on a port does not always name the same storage: depending on the current mode, some numbers select a private copy that belongs to that mode. The fast-interrupt mode keeps seven private registers so that its handler can run without saving anything, the other exception modes keep private copies of only the stack pointer and link register, and the System mode works on the User copies.

The array offers two combinational read ports and one write port that updates on the clock edge, all addressed by a 4-bit register number, plus a separate port for the saved status word of the current exception mode. The program counter (register 15) lives outside the array and is merged into the operand path by the surrounding datapath. A user-bank control lets context-switch code reach the User copies from any privileged mode.

Top module: `bankreg_file`

## Requirements
- R1: Both read ports return, in the same cycle, the register addressed by their 4-bit select under the current mode; a write with `wr_en` high stores `wr_data` into the addressed register at the rising clock edge.
- R2: Registers 0 to 7 are one set of storage shared by every mode.
- R3: In fast-interrupt mode (mode code 10001) registers 8 to 14 select copies private to that mode.
- R4: In interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, registers 13 and 14 select copies private to each of those modes, while registers 8 to 12 select the User copies.
- R5: System mode (11111) uses exactly the User registers (User is 10000); any mode code not listed is treated as User.
- R6: With `user_bank` high, reads and writes of registers 8 to 14 use the User copies whatever the mode; the private copies are left untouched.
- R7: Each of the five exception modes has its own saved status word, read on `sps_rd_data` and written through `sps_wr_en`/`sps_wr_data` by the current mode; `user_bank` does not affect this port.
- R8: In User, System or an unlisted mode the saved status port reads zero and a write to it changes no stored word.
- R9: Register 15 is not stored: reading it returns zero and writing it has no effect.
- R10: A read of a register being written in the same cycle returns the old value; the new value appears from the next cycle.
- R11: A synchronous active-low reset clears every register and every saved status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 5 | Current operating mode code |
| user_bank | input | 1 | Force the User copies for the general register ports |
| rd_a_sel | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| sps_wr_en | input | 1 | Saved status write enable |
| sps_wr_data | input | 32 | Saved status write data |
| sps_rd_data | output | 32 | Saved status word of the current mode |

## Verification
The assertions assume `mode`, `user_bank` and the select inputs are known and held across each clock edge, and that the write-visibility check only judges a read whose select, mode and bank control match the preceding write. The bench changes every input half a period away from the rising edge, only ever drives the seven listed mode codes plus one deliberately unlisted code, and keeps write and read addresses aligned when it tests same-cycle behaviour.

// File: rtl/bankreg_pkg.sv
// Shared definitions for the mode-banked register file.
// Assumes a 5-bit mode code and 4-bit register numbers.
package bankreg_pkg;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    // Storage bank in use; System and unlisted codes fold onto BK_USR.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_t;

    localparam int N_SHARED   = 8;   // registers 0..7 common to all modes
    localparam int FIQ_FIRST  = 8;   // first register private to fast interrupt
    localparam int N_FIQ_PRIV = 7;   // registers 8..14
    localparam int SP_NUM     = 13;  // first register private to other exception modes
    localparam int N_EXC_PRIV = 2;   // stack pointer and link register
    localparam int PC_NUM     = 15;  // held outside the array
    localparam int N_EXC      = 4;   // IRQ, SVC, ABT, UND
    localparam int N_SPSR     = 5;   // one saved status word per exception mode

    // Physical layout: shared + User 8..14, then fast-interrupt copies, then pairs.
    localparam int FIQ_BASE  = N_SHARED + N_FIQ_PRIV;
    localparam int PAIR_BASE = FIQ_BASE + N_FIQ_PRIV;
    localparam int N_PHYS    = PAIR_BASE + N_EXC * N_EXC_PRIV;

    // Translate a mode code into the bank that owns its private storage.
    function automatic bank_t decode_mode(input logic [4:0] m);
        case (m)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bankreg_map.sv
// Maps a register number and a bank onto a physical slot of the array.
// Assumes the layout constants of bankreg_pkg; register 15 yields valid=0.
module bankreg_map
    import bankreg_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int IDX_W = $clog2(N_PHYS)
) (
    input  logic [SEL_W-1:0] sel,
    input  bank_t            bank,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    // Combinational slot selection by register number and bank.
    always_comb begin
        int r;
        int slot;
        r     = int'(sel);
        valid = (r != PC_NUM);
        if (r < N_SHARED || bank == BK_USR) begin
            slot = r;
        end else if (bank == BK_FIQ) begin
            slot = FIQ_BASE + (r - FIQ_FIRST);
        end else if (r >= SP_NUM && r < SP_NUM + N_EXC_PRIV) begin
            slot = PAIR_BASE + (int'(bank) - int'(BK_IRQ)) * N_EXC_PRIV + (r - SP_NUM);
        end else begin
            slot = r;
        end
        if (!valid) slot = 0;
        idx = IDX_W'(slot);
    end

endmodule

// File: rtl/bankreg_spsr.sv
// Saved status words, one per exception mode, addressed by the current bank.
// Assumes bank comes from the mode code alone (never forced to User).
module bankreg_spsr
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_t             bank,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int SLOT_W = $clog2(N_SPSR);

    logic [N_SPSR-1:0][DATA_W-1:0] store;
    logic [SLOT_W-1:0]             slot;
    logic                          owned;

    // Slot of the current exception mode; User/System own none.
    always_comb begin
        owned = (bank != BK_USR);
        slot  = owned ? SLOT_W'(int'(bank) - int'(BK_FIQ)) : '0;
    end

    // Clear on reset, otherwise update the owning mode's word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_en && owned) begin
            store[slot] <= wr_data;
        end
    end

    // Present the current mode's word, zero when it has none.
    always_comb begin
        rd_data = owned ? store[slot] : '0;
    end

    p_spsr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BK_USR) |-> (rd_data == '0));

    p_spsr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank == BK_USR) |=> $stable(store));

endmodule

// File: rtl/bankreg_file.sv
// Top of the mode-banked register file: two read ports, one write port,
// saved status port. Assumes inputs are stable around the rising edge;
// register 15 is supplied outside and reads zero here.
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    parameter int MODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              user_bank,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sps_wr_en,
    input  logic [DATA_W-1:0] sps_wr_data,
    output logic [DATA_W-1:0] sps_rd_data
);

    localparam int IDX_W   = $clog2(N_PHYS);
    localparam int N_PORTS = 3;  // 0: read A, 1: read B, 2: write

    bank_t              mode_bank;
    bank_t              reg_bank;
    logic [SEL_W-1:0]   port_sel   [N_PORTS];
    logic [IDX_W-1:0]   port_idx   [N_PORTS];
    logic               port_valid [N_PORTS];
    logic [DATA_W-1:0]  regs       [N_PHYS];

    // Bank for the general ports, with the User override applied.
    always_comb begin
        mode_bank   = decode_mode(mode);
        reg_bank    = user_bank ? BK_USR : mode_bank;
        port_sel[0] = rd_a_sel;
        port_sel[1] = rd_b_sel;
        port_sel[2] = wr_sel;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        bankreg_map #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_map (
            .sel   (port_sel[p]),
            .bank  (reg_bank),
            .idx   (port_idx[p]),
            .valid (port_valid[p])
        );
    end

    // Register array: synchronous clear, single write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PHYS; i++) regs[i] <= '0;
        end else if (wr_en && port_valid[2]) begin
            regs[port_idx[2]] <= wr_data;
        end
    end

    // Combinational read ports; register 15 reads zero.
    always_comb begin
        rd_a_data = port_valid[0] ? regs[port_idx[0]] : '0;
        rd_b_data = port_valid[1] ? regs[port_idx[1]] : '0;
    end

    bankreg_spsr #(.DATA_W(DATA_W)) u_spsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (mode_bank),
        .wr_en   (sps_wr_en),
        .wr_data (sps_wr_data),
        .rd_data (sps_rd_data)
    );

    p_ports_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == rd_b_sel) |-> (rd_a_data == rd_b_data));

    p_pc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == SEL_W'(PC_NUM)) |-> (rd_a_data == '0));

    p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != SEL_W'(PC_NUM)) |=>
        (rd_a_sel != $past(wr_sel) || mode != $past(mode) ||
         user_bank != $past(user_bank) || rd_a_data == $past(wr_data)));

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_a_data == '0 && sps_rd_data == '0));

endmodule

// File: tb/sim_bankreg_file.sv
module sim_bankreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic        user_bank = 1'b0;
    logic [3:0]  rd_a_sel = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_sel = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        sps_wr_en = 1'b0;
    logic [31:0] sps_wr_data = '0;
    logic [31:0] sps_rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bankreg_file u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .user_bank(user_bank),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sps_wr_en(sps_wr_en), .sps_wr_data(sps_wr_data),
        .sps_rd_data(sps_rd_data)
    );

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, BAD = 5'b00000;

    // Vector: [46] write, [45:41] mode, [40] user_bank, [39:36] register,
    // [35:32] requirement number, [31:0] write data or expected read.
    localparam int NVEC = 28;
    localparam logic [46:0] VEC [NVEC] = '{
        {1'b1, USR, 1'b0, 4'd0,  4'd1,  32'h0000_0100},
        {1'b1, USR, 1'b0, 4'd8,  4'd1,  32'h0000_0108},
        {1'b1, USR, 1'b0, 4'd13, 4'd1,  32'h0000_010D},
        {1'b1, USR, 1'b0, 4'd14, 4'd1,  32'h0000_010E},
        {1'b1, FIQ, 1'b0, 4'd8,  4'd3,  32'h0000_0208},
        {1'b1, FIQ, 1'b0, 4'd13, 4'd3,  32'h0000_020D},
        {1'b1, IRQ, 1'b0, 4'd13, 4'd4,  32'h0000_030D},
        {1'b1, SVC, 1'b0, 4'd14, 4'd4,  32'h0000_040E},
        {1'b1, ABT, 1'b0, 4'd13, 4'd4,  32'h0000_050D},
        {1'b1, UND, 1'b0, 4'd13, 4'd4,  32'h0000_060D},
        {1'b1, SVC, 1'b0, 4'd0,  4'd2,  32'h0000_0999},
        {1'b1, FIQ, 1'b1, 4'd9,  4'd6,  32'h0000_0109},
        {1'b0, SYS, 1'b0, 4'd0,  4'd2,  32'h0000_0999},   // R2 shared low
        {1'b0, FIQ, 1'b0, 4'd0,  4'd2,  32'h0000_0999},   // R2
        {1'b0, USR, 1'b0, 4'd8,  4'd1,  32'h0000_0108},   // R1
        {1'b0, FIQ, 1'b0, 4'd8,  4'd3,  32'h0000_0208},   // R3 private copy
        {1'b0, FIQ, 1'b0, 4'd14, 4'd3,  32'h0000_0000},   // R3 untouched copy
        {1'b0, IRQ, 1'b0, 4'd8,  4'd4,  32'h0000_0108},   // R4 8..12 are User
        {1'b0, IRQ, 1'b0, 4'd13, 4'd4,  32'h0000_030D},   // R4
        {1'b0, SVC, 1'b0, 4'd13, 4'd4,  32'h0000_0000},   // R4 separate
        {1'b0, SVC, 1'b0, 4'd14, 4'd4,  32'h0000_040E},   // R4
        {1'b0, ABT, 1'b0, 4'd13, 4'd4,  32'h0000_050D},   // R4
        {1'b0, UND, 1'b0, 4'd13, 4'd4,  32'h0000_060D},   // R4
        {1'b0, SYS, 1'b0, 4'd13, 4'd5,  32'h0000_010D},   // R5 System = User
        {1'b0, BAD, 1'b0, 4'd14, 4'd5,  32'h0000_010E},   // R5 unlisted code
        {1'b0, USR, 1'b0, 4'd9,  4'd6,  32'h0000_0109},   // R6 forced write
        {1'b0, FIQ, 1'b0, 4'd9,  4'd6,  32'h0000_0000},   // R6 private left alone
        {1'b0, FIQ, 1'b1, 4'd13, 4'd6,  32'h0000_010D}    // R6 forced read
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] m, input logic ub, input logic [3:0] s,
                             input logic [31:0] d);
        @(negedge clk);
        mode = m; user_bank = ub; wr_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_check(input logic [4:0] m, input logic ub, input logic [3:0] s,
                             input logic [31:0] exp, input string tag);
        @(negedge clk);
        mode = m; user_bank = ub; rd_a_sel = s; rd_b_sel = s;
        #1;
        check({tag, " port A"}, rd_a_data, exp);
        check({tag, " port B"}, rd_b_data, exp);
    endtask

    task automatic sps_write(input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        mode = m; sps_wr_data = d; sps_wr_en = 1'b1;
        @(negedge clk);
        sps_wr_en = 1'b0;
    endtask

    task automatic sps_check(input logic [4:0] m, input logic [31:0] exp, input string tag);
        @(negedge clk);
        mode = m;
        #1;
        check(tag, sps_rd_data, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        reg_check(USR, 1'b0, 4'd0,  32'h0, "R11 reset reg0");
        reg_check(FIQ, 1'b0, 4'd8,  32'h0, "R11 reset fiq8");
        reg_check(UND, 1'b0, 4'd14, 32'h0, "R11 reset und14");
        sps_check(IRQ, 32'h0, "R11 reset saved status");

        for (int i = 0; i < NVEC; i++) begin
            logic [46:0] v;
            v = VEC[i];
            if (v[46]) reg_write(v[45:41], v[40], v[39:36], v[31:0]);
            else reg_check(v[45:41], v[40], v[39:36], v[31:0],
                           $sformatf("R%0d vector %0d", v[35:32], i));
        end

        // R9 register 15 not stored
        reg_write(USR, 1'b0, 4'd15, 32'hDEAD_BEEF);
        reg_check(USR, 1'b0, 4'd15, 32'h0, "R9 pc reads zero");
        reg_check(USR, 1'b0, 4'd0, 32'h0000_0999, "R9 write to 15 lands nowhere");

        // R10 same-cycle write and read
        reg_write(USR, 1'b0, 4'd3, 32'h0000_1234);
        @(negedge clk);
        mode = USR; user_bank = 1'b0; rd_a_sel = 4'd3; rd_b_sel = 4'd3;
        wr_sel = 4'd3; wr_data = 32'h0000_AAAA; wr_en = 1'b1;
        #1;
        check("R10 old value during write", rd_a_data, 32'h0000_1234);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 new value next cycle", rd_a_data, 32'h0000_AAAA);

        // R7 and R8 saved status port
        sps_write(IRQ, 32'h0000_0011);
        sps_write(SVC, 32'h0000_0022);
        sps_write(USR, 32'h0000_0077);
        sps_write(SYS, 32'h0000_0088);
        user_bank = 1'b1;
        sps_check(IRQ, 32'h0000_0011, "R7 irq word, user_bank ignored");
        user_bank = 1'b0;
        sps_check(SVC, 32'h0000_0022, "R7 svc word");
        sps_check(FIQ, 32'h0, "R8 fiq untouched by user write");
        sps_check(ABT, 32'h0, "R8 abt untouched by user write");
        sps_check(UND, 32'h0, "R8 und untouched by user write");
        sps_check(USR, 32'h0, "R8 user reads zero");
        sps_check(SYS, 32'h0, "R8 system reads zero");

        // R11 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reg_check(USR, 1'b0, 4'd3, 32'h0, "R11 mid-run reg3");
        reg_check(FIQ, 1'b0, 4'd8, 32'h0, "R11 mid-run fiq8");
        sps_check(SVC, 32'h0, "R11 mid-run saved status");

        finish_run();
    end

endmodule